// File: doc/BRIEF.md
# Page-Granular Memory Protection Unit

This block watches the physical addresses a processor issues and compares each one against four programmable protected windows. A window is described by a first and a last page number, where a page is 1024 bytes and the page of an access is its address shifted right by ten. Each window also carries a two-bit permission code that may allow reads, writes, both or neither. An access that lands inside a window and is not allowed by that window's code is a violation.

A violation sets the interrupt flag of the matching channel and, if no flag was already pending, latches the faulting address. The address is split across two 16-bit read-only registers. Software reads the address, then clears the flags by writing ones to them. A single interrupt line is asserted when the global enable is on and at least one channel has both its flag and its enable set. The block only reports violations. It does not stop or abort the offending transfer.

Configuration uses a synchronous 16-bit register port addressed by byte offset. Read data appears one clock after the request.

Top module: `pgprot_unit`

## Requirements
- R1: After reset, every bound, the permission code, the mask and the flags read 0, and `irq` is low.
- R2: The page of an access is `acc_addr >> 10`. An access hits window N when first_N <= page <= last_N, with both bounds inclusive.
- R3: Permission codes work as follows. Bit 0 of a code allows reads and bit 1 allows writes, so 00 allows no access, 01 allows reads only, 10 allows writes only and 11 allows both. A hit whose direction is not allowed is a violation of that window.
- R4: A violation of window N sets flag bit N at the clock edge that samples the access. When several windows are violated in one cycle, all of their flags are set.
- R5: The flag register sits at offset 0x1E.
  - Bits 3:0 are the channel flags and bit 4 reads as the OR of bits 3:0.
  - Writing 1 to bits 3:0 clears those flags. Writing 0 leaves them unchanged.
  - A violation in the same cycle as a clear leaves that flag set.
- R6: The mask register sits at offset 0x1C. Bits 3:0 are channel enables and bit 4 is the global enable. `irq` is high exactly when bit 4 is 1 and (flags & mask[3:0]) is nonzero.
- R7: The fault address is captured when a violation occurs while all flags are 0, and is otherwise held.
  - Offset 0x24 bits 13:0 hold address bits 29:16.
  - Offset 0x22 bits 15:5 hold address bits 15:5, and bits 4:0 read 0.
- R8: Window N occupies byte offset 4N (first page) and 4N+2 (last page). The upper half of each 32-bit window register sits at the lower address, and both halves are readable and writable.
- R9: The permission register at offset 0x10 holds the code of channel N in bits 2N+1:2N. Bits 15:8 read 0.
- R10: Read data is valid one clock after a read request. Unmapped offsets read 0.
- R11: An access that hits no window, or arrives while `acc_valid` is low, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after the request |
| acc_valid | input | 1 | Monitored access present this cycle |
| acc_write | input | 1 | Monitored access is a write |
| acc_addr | input | 32 | Physical address of the monitored access |
| irq | output | 1 | Combined protection interrupt |

## Verification
The bench probes the first page, the last page and the pages just outside them, so a design with an exclusive bound or a mis-shifted page number either misses a fault or reports a false one. It sets each permission code on both read and write traffic; a design with swapped code bits flags the wrong direction. One write violates two overlapping windows, and a second fault follows before the flags are cleared. A design that keeps only one flag, or that overwrites the captured address, reads back the wrong values. A flag clear is issued in the same cycle as a new fault, and the mask is tried with the global enable both off and on. Either mistake shows up as a lost flag or a wrong `irq` level.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  localparam int NUM_RGN = 4;
  localparam int PG_W    = 16;
  localparam int DATA_W  = 16;
  localparam int OFS_W   = 8;

  localparam logic [OFS_W-1:0] OFS_PERM = 8'h10;
  localparam logic [OFS_W-1:0] OFS_MASK = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_FLAG = 8'h1E;
  localparam logic [OFS_W-1:0] OFS_FLO  = 8'h22;
  localparam logic [OFS_W-1:0] OFS_FHI  = 8'h24;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RD   = 2'b01,
    PERM_WR   = 2'b10,
    PERM_RW   = 2'b11
  } perm_e;

  typedef struct packed {
    logic [PG_W-1:0] first;
    logic [PG_W-1:0] last;
  } bounds_t;

  // byte offset of the first-page half (hi=1) or last-page half (hi=0)
  function automatic logic [OFS_W-1:0] bound_ofs(input int idx, input logic hi);
    return OFS_W'(4 * idx + (hi ? 0 : 2));
  endfunction

  // direction not allowed by code: read needs bit 0, write needs bit 1
  function automatic logic denies(input perm_e code, input logic is_wr);
    return is_wr ? ~code[1] : ~code[0];
  endfunction

endpackage

// File: rtl/pgprot_cfg.sv
module pgprot_cfg
  import pgprot_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [OFS_W-1:0]             addr,
  input  logic [DATA_W-1:0]            wdata,
  output bounds_t [NUM_RGN-1:0]        bounds_o,
  output logic [2*NUM_RGN-1:0]         perm_o,
  output logic [NUM_RGN:0]             mask_o
);

  localparam int PERM_BITS = 2 * NUM_RGN;

  bounds_t [NUM_RGN-1:0]  bounds_q;
  logic [PERM_BITS-1:0]   perm_q;
  logic [NUM_RGN:0]       mask_q;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic hit_first, hit_last;
    assign hit_first = wr_en && (addr == bound_ofs(g, 1'b1));
    assign hit_last  = wr_en && (addr == bound_ofs(g, 1'b0));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bounds_q[g] <= '0;
      end else begin
        if (hit_first) bounds_q[g].first <= wdata;
        if (hit_last)  bounds_q[g].last  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_PERM) perm_q <= wdata[PERM_BITS-1:0];
      if (addr == OFS_MASK) mask_q <= wdata[NUM_RGN:0];
    end
  end

  assign bounds_o = bounds_q;
  assign perm_o   = perm_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/pgprot_match.sv
module pgprot_match
  import pgprot_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10
) (
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  bounds_t [NUM_RGN-1:0] bounds,
  input  logic [2*NUM_RGN-1:0]  perm,
  output logic [NUM_RGN-1:0]    hit_vec,
  output logic [NUM_RGN-1:0]    viol_vec
);

  function automatic logic in_window(input logic [ADDR_W-1:0] pg, input bounds_t b);
    return (pg >= ADDR_W'(b.first)) && (pg <= ADDR_W'(b.last));
  endfunction

  logic [ADDR_W-1:0] page;
  assign page = acc_addr >> PAGE_SHIFT;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_chk
    perm_e code;
    assign code        = perm_e'(perm[2*g +: 2]);
    assign hit_vec[g]  = acc_valid && in_window(page, bounds[g]);
    assign viol_vec[g] = hit_vec[g] && denies(code, acc_write);
  end

endmodule

// File: rtl/pgprot_fault.sv
module pgprot_fault
  import pgprot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RGN-1:0] viol_vec,
  input  logic               flag_wr,
  input  logic [NUM_RGN-1:0] clr_bits,
  input  logic [13:0]        addr_hi,
  input  logic [10:0]        addr_lo,
  input  logic [NUM_RGN:0]   mask,
  output logic [NUM_RGN-1:0] flags_o,
  output logic [DATA_W-1:0]  fault_lo_o,
  output logic [DATA_W-1:0]  fault_hi_o,
  output logic               capture_evt,
  output logic               irq_o
);

  logic [NUM_RGN-1:0] flags_q;
  logic [NUM_RGN-1:0] clr_mask;
  logic [10:0]        lo_q;
  logic [13:0]        hi_q;

  assign clr_mask    = flag_wr ? clr_bits : '0;
  assign capture_evt = (|viol_vec) && (flags_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | viol_vec;
      if (capture_evt) begin
        lo_q <= addr_lo;
        hi_q <= addr_hi;
      end
    end
  end

  assign flags_o    = flags_q;
  assign fault_lo_o = {lo_q, 5'b0};
  assign fault_hi_o = {2'b0, hi_q};
  assign irq_o      = mask[NUM_RGN] && ((flags_q & mask[NUM_RGN-1:0]) != '0);

endmodule

// File: rtl/pgprot_unit.sv
module pgprot_unit
  import pgprot_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              irq
);

  bounds_t [NUM_RGN-1:0]  bounds_q;
  logic [2*NUM_RGN-1:0]   perm_q;
  logic [NUM_RGN:0]       mask_q;
  logic [NUM_RGN-1:0]     hit_vec;
  logic [NUM_RGN-1:0]     viol_vec;
  logic [NUM_RGN-1:0]     flags_q;
  logic [DATA_W-1:0]      fault_lo_q;
  logic [DATA_W-1:0]      fault_hi_q;
  logic                   capture_evt;
  logic                   wr_en;
  logic                   rd_en;
  logic                   flag_wr;
  logic [DATA_W-1:0]      rd_mux;
  logic [DATA_W-1:0]      rdata_q;

  assign wr_en   = reg_en && reg_wr;
  assign rd_en   = reg_en && !reg_wr;
  assign flag_wr = wr_en && (reg_addr == OFS_FLAG);

  pgprot_cfg cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .bounds_o (bounds_q),
    .perm_o   (perm_q),
    .mask_o   (mask_q)
  );

  pgprot_match #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) match_i (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .bounds    (bounds_q),
    .perm      (perm_q),
    .hit_vec   (hit_vec),
    .viol_vec  (viol_vec)
  );

  pgprot_fault fault_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .viol_vec    (viol_vec),
    .flag_wr     (flag_wr),
    .clr_bits    (reg_wdata[NUM_RGN-1:0]),
    .addr_hi     (acc_addr[29:16]),
    .addr_lo     (acc_addr[15:5]),
    .mask        (mask_q),
    .flags_o     (flags_q),
    .fault_lo_o  (fault_lo_q),
    .fault_hi_o  (fault_hi_q),
    .capture_evt (capture_evt),
    .irq_o       (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (reg_addr == bound_ofs(i, 1'b1)) rd_mux = bounds_q[i].first;
      if (reg_addr == bound_ofs(i, 1'b0)) rd_mux = bounds_q[i].last;
    end
    case (reg_addr)
      OFS_PERM: rd_mux = DATA_W'(perm_q);
      OFS_MASK: rd_mux = DATA_W'(mask_q);
      OFS_FLAG: rd_mux = DATA_W'({|flags_q, flags_q});
      OFS_FLO:  rd_mux = fault_lo_q;
      OFS_FHI:  rd_mux = fault_hi_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/pgprot_checker.sv
module pgprot_checker
  import pgprot_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               acc_valid,
  input logic [NUM_RGN-1:0] flags,
  input logic [NUM_RGN:0]   mask,
  input logic [NUM_RGN-1:0] viol,
  input logic [DATA_W-1:0]  fault_lo,
  input logic [DATA_W-1:0]  fault_hi
);

  assert_irq_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask[NUM_RGN]);

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (viol != '0) |=> ((flags & $past(viol)) == $past(viol)));

  assert_flag_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol == '0) |=> ((flags & ~$past(flags)) == '0));

  assert_viol_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (viol != '0) |-> acc_valid);

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |=> ($stable(fault_lo) && $stable(fault_hi)));

endmodule

bind pgprot_unit pgprot_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .acc_valid (acc_valid),
  .flags     (flags_q),
  .mask      (mask_q),
  .viol      (viol_vec),
  .fault_lo  (fault_lo_q),
  .fault_hi  (fault_hi_q)
);

// File: tb/pgprot_unit_tb.sv
`timescale 1ns/1ps
module pgprot_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pgprot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 irq after reset", 32'(irq), 0);
    for (int i = 0; i < 8; i++) begin
      rd(8'(2 * i), d);
      chk("R1 bound reset", 32'(d), 0);
    end
    rd(8'h10, d); chk("R1 perm reset", 32'(d), 0);
    rd(8'h1C, d); chk("R1 mask reset", 32'(d), 0);
    rd(8'h1E, d); chk("R1 flag reset", 32'(d), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(8'h00, 16'h0010); wr(8'h02, 16'h0012);
    wr(8'h0C, 16'hBEEF); wr(8'h0E, 16'h1234);
    rd(8'h00, d); chk("R8 rgn0 first", 32'(d), 32'h0010);
    rd(8'h02, d); chk("R8 rgn0 last", 32'(d), 32'h0012);
    rd(8'h0C, d); chk("R8 rgn3 first", 32'(d), 32'hBEEF);
    rd(8'h0E, d); chk("R8 rgn3 last", 32'(d), 32'h1234);
    wr(8'h10, 16'hFFFF);
    rd(8'h10, d); chk("R9 perm upper bits zero", 32'(d), 32'h00FF);
    wr(8'h10, 16'h0000);
    wr(8'h0C, 16'h0000); wr(8'h0E, 16'h0000);
    rd(8'h30, d); chk("R10 unmapped reads zero", 32'(d), 0);
    @(negedge clk); reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 8'h02;
    @(posedge clk); #1;
    chk("R10 data after one edge", 32'(reg_rdata), 32'h0012);
    @(negedge clk); reg_en = 1'b0;
  endtask

  task automatic t_bounds();
    logic [15:0] d;
    wr(8'h1C, 16'h001F);
    acc(32'h0000_3C00, 1'b0);
    rd(8'h1E, d); chk("R11 page below window", 32'(d), 0);
    @(negedge clk); acc_valid = 1'b0; acc_addr = 32'h0000_4000; acc_write = 1'b0;
    @(negedge clk);
    rd(8'h1E, d); chk("R11 invalid access ignored", 32'(d), 0);
    acc(32'h0000_4000, 1'b0);
    chk("R6 irq on fault", 32'(irq), 1);
    rd(8'h1E, d); chk("R2 first page hit", 32'(d), 32'h11);
    rd(8'h22, d); chk("R7 lo first page", 32'(d), 32'h4000);
    rd(8'h24, d); chk("R7 hi first page", 32'(d), 0);
    wr(8'h1E, 16'h000F);
    rd(8'h1E, d); chk("R5 clear", 32'(d), 0);
    chk("R6 irq low after clear", 32'(irq), 0);
    acc(32'h0000_4BFF, 1'b1);
    rd(8'h1E, d); chk("R2 last page hit", 32'(d), 32'h11);
    rd(8'h22, d); chk("R7 lo bits 4:0 zero", 32'(d), 32'h4BE0);
    wr(8'h1E, 16'h000F);
    acc(32'h0000_4C00, 1'b0);
    rd(8'h1E, d); chk("R2 page above window", 32'(d), 0);
  endtask

  task automatic t_perm();
    logic [15:0] d;
    wr(8'h04, 16'h0100); wr(8'h06, 16'h0100);
    wr(8'h10, 16'h0004);
    acc(32'h0004_0000, 1'b0);
    rd(8'h1E, d); chk("R3 read-only allows read", 32'(d), 0);
    acc(32'h0004_0000, 1'b1);
    rd(8'h1E, d); chk("R3 read-only faults write", 32'(d), 32'h12);
    wr(8'h1E, 16'h000F);
    wr(8'h10, 16'h0008);
    acc(32'h0004_0000, 1'b1);
    rd(8'h1E, d); chk("R3 write-only allows write", 32'(d), 0);
    acc(32'h0004_0000, 1'b0);
    rd(8'h1E, d); chk("R3 write-only faults read", 32'(d), 32'h12);
    wr(8'h1E, 16'h000F);
    wr(8'h10, 16'h000C);
    acc(32'h0004_0000, 1'b0);
    acc(32'h0004_03FF, 1'b1);
    rd(8'h1E, d); chk("R3 read-write allows both", 32'(d), 0);
  endtask

  task automatic t_multi();
    logic [15:0] d;
    wr(8'h08, 16'hA000); wr(8'h0A, 16'hAFFF);
    wr(8'h0C, 16'hA800); wr(8'h0E, 16'hA800);
    wr(8'h10, 16'h004C);
    acc(32'h02A0_0060, 1'b1);
    rd(8'h1E, d); chk("R4 two windows flagged", 32'(d), 32'h1C);
    rd(8'h24, d); chk("R7 hi captured", 32'(d), 32'h02A0);
    rd(8'h22, d); chk("R7 lo captured", 32'(d), 32'h0060);
    acc(32'h02A0_0400, 1'b0);
    rd(8'h24, d); chk("R7 hi held on second fault", 32'(d), 32'h02A0);
    rd(8'h22, d); chk("R7 lo held on second fault", 32'(d), 32'h0060);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(8'h1C, 16'h000C);
    chk("R6 no global enable", 32'(irq), 0);
    wr(8'h1C, 16'h0013);
    chk("R6 enabled channels not pending", 32'(irq), 0);
    wr(8'h1C, 16'h0018);
    chk("R6 ch3 enabled and pending", 32'(irq), 1);
    rd(8'h1C, d); chk("R6 mask readback", 32'(d), 32'h18);
    wr(8'h1E, 16'h0004);
    rd(8'h1E, d); chk("R5 single bit clear", 32'(d), 32'h18);
    wr(8'h1E, 16'h0000);
    rd(8'h1E, d); chk("R5 zero write no effect", 32'(d), 32'h18);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h1E; reg_wdata = 16'h0008;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h02A0_0060;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0; acc_valid = 1'b0;
    rd(8'h1E, d); chk("R5 fault wins over clear", 32'(d), 32'h1C);
    wr(8'h1E, 16'h001F);
    rd(8'h1E, d); chk("R5 all cleared", 32'(d), 0);
    chk("R6 irq low after full clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_bounds();
    t_perm();
    t_multi();
    t_mask();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule